// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block gathers every interrupt request a CPU core can see and decides which one the core serves next. Six non-maskable sources, one source gated by the X mask and a parameterised set of level-programmed sources gated by the I mask all compete. The controller turns the winner into a 16-bit vector address. Software sets the upper byte of that address, and each source class has a fixed lower byte. A request is taken only when its level is strictly above the level the core is already running at, so handlers can nest. When the core fetches a vector, the running level moves to the winner's level and the old level is saved on a small stack. A return pulse restores the saved level.

Each level-programmed source can also be steered to a coprocessor. Steered sources are offered through a valid/ready channel that carries the winning channel index. The coprocessor may hold `cop_ready` low for as long as it likes, and the offer stays put while the requests are unchanged. A handshake marks that channel as taken, and the channel is not offered again until its request line drops. A separate combinational output gives the fixed restart address for each kind of reset.

Top module: `ivc_top`

## Requirements
- R1: After reset the base byte is 0xFF, every level-programmed source has level 1 and is steered to the CPU, the running level is 0, `cpu_int` and `cop_valid` are low and `cpu_vec` reads 0xFF10.
- R2: `cpu_vec` is {base byte, offset}. Level-programmed source k uses offset 0x1A+2k. Config address 0 writes the base byte. Address k+1 writes source k, with the level in bits 2:0 and the steering bit in bit 7 (1 selects the coprocessor).
- R3: The `nm_req` bits are ranked trap (bit 5, 0xF8) over software interrupt (bit 4, 0xF6), then access faults bit 3, bit 2 and bit 1 (0x18, 0x16, 0x14), then system call (bit 0, 0x12). Neither mask affects them.
- R4: The X source (0xF4) ranks below every non-maskable source and above all level-programmed sources. It is blocked only by `xmask`.
- R5: `imask` blocks only level-programmed sources, and a source at level 0 never requests.
- R6: Among eligible CPU-steered sources, the highest level wins. On equal levels the higher index (higher vector) wins.
- R7: A level-programmed source is eligible for the CPU only if its level is strictly greater than `cpu_ipl`.
- R8: On `cpu_fetch`, the current level is pushed. The level becomes the winner's level for a level-programmed vector and stays the same for any other vector. A `cpu_rti` pulse without a fetch pops the saved level. If both arrive together, the fetch takes effect.
- R9: Sources steered to the coprocessor never reach the CPU. The highest-index source (the external pin) always goes to the CPU, whatever its steering bit.
- R10: `cop_valid` is high when any untaken, coprocessor-steered source at a non-zero level is requesting, and `cop_chan` follows the R6 ranking. Masks and `cpu_ipl` have no effect here. After a handshake, that channel is withheld until its request is low at a clock edge.
- R11: When no request is eligible, `cpu_int` is low and `cpu_vec` holds the spurious offset 0x10. A fetch in that state still pushes and keeps the level.
- R12: `boot_vec` is 0xFFFE for `rst_cause` 0 or 3, 0xFFFC for 1 and 0xFFFA for 2, independent of the base byte.
- R13: The level stack holds STK_D entries. A push when full drops the oldest entry, and a pop of an empty stack yields level 0.
- R14: Config writes to addresses above NUM_I change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Config write strobe |
| cfg_addr | input | AW | Config address (0 = base byte, k+1 = source k) |
| cfg_wdata | input | 8 | Config write data |
| nm_req | input | 6 | Non-maskable requests, bit meaning per R3 |
| xirq | input | 1 | X-maskable request |
| xmask | input | 1 | X mask from the CPU condition codes |
| imask | input | 1 | I mask from the CPU condition codes |
| irq | input | NUM_I | Level-programmed requests |
| cpu_int | output | 1 | Interrupt request to the CPU |
| cpu_vec | output | 16 | Vector address for the CPU |
| cpu_fetch | input | 1 | CPU takes the vector this cycle |
| cpu_rti | input | 1 | CPU returns from a handler |
| cpu_ipl | output | 3 | Current running level |
| cop_valid | output | 1 | Coprocessor offer valid |
| cop_chan | output | IW | Offered channel index |
| cop_ready | input | 1 | Coprocessor accepts the offer |
| rst_cause | input | 2 | Reset kind for the restart address |
| boot_vec | output | 16 | Restart address |

## Verification
The assertions assume that `cpu_fetch` is a single-cycle pulse and that the configuration is written while no fetch is under way. They also assume that `nm_req`, `xirq` and `irq` change only between clock edges, so each cycle's winner is settled at the edge. The bench drives every input half a period away from the rising edge. It writes configuration only while all requests are idle, and it never raises `cpu_fetch` and `cpu_rti` in the same cycle. That last rule keeps the nesting checks free of the same-cycle collision case.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  localparam int LVL_W = 3;

  localparam logic [7:0] OFF_SPUR = 8'h10;
  localparam logic [7:0] OFF_SYS  = 8'h12;
  localparam logic [7:0] OFF_ACC0 = 8'h14;
  localparam logic [7:0] OFF_ACC1 = 8'h16;
  localparam logic [7:0] OFF_ACC2 = 8'h18;
  localparam logic [7:0] OFF_I0   = 8'h1A;
  localparam logic [7:0] OFF_X    = 8'hF4;
  localparam logic [7:0] OFF_SWI  = 8'hF6;
  localparam logic [7:0] OFF_TRAP = 8'hF8;

  localparam int NM_SYS  = 0;
  localparam int NM_ACC0 = 1;
  localparam int NM_ACC1 = 2;
  localparam int NM_ACC2 = 3;
  localparam int NM_SWI  = 4;
  localparam int NM_TRAP = 5;
  localparam int NM_N    = 6;

  localparam logic [15:0] BOOT_POR = 16'hFFFE;
  localparam logic [15:0] BOOT_CLK = 16'hFFFC;
  localparam logic [15:0] BOOT_WDG = 16'hFFFA;

  typedef enum logic [1:0] {SRC_SPUR, SRC_NM, SRC_X, SRC_I} src_kind_t;
endpackage

// File: rtl/ivc_cfg.sv
module ivc_cfg
  import ivc_pkg::*;
#(
  parameter int NUM_I = 8,
  parameter int AW    = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [AW-1:0]          addr,
  input  logic [7:0]             wdata,
  output logic [7:0]             base_o,
  output logic [NUM_I*LVL_W-1:0] lvl_o,
  output logic [NUM_I-1:0]       route_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        base_o <= 8'hFF;
    else if (we && addr == AW'(0))     base_o <= wdata;
  end

  for (genvar k = 0; k < NUM_I; k++) begin : g_src
    logic hit;
    assign hit = we && (addr == AW'(k + 1));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   lvl_o[k*LVL_W +: LVL_W] <= LVL_W'(1);
      else if (hit) lvl_o[k*LVL_W +: LVL_W] <= wdata[LVL_W-1:0];
    end

    if (k == NUM_I - 1) begin : g_pin
      assign route_o[k] = 1'b0;
    end else begin : g_routable
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   route_o[k] <= 1'b0;
        else if (hit) route_o[k] <= wdata[7];
      end
    end
  end
endmodule

// File: rtl/ivc_pick.sv
module ivc_pick
  import ivc_pkg::*;
#(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]       en,
  input  logic [N*LVL_W-1:0] lvl,
  output logic               hit,
  output logic [IW-1:0]      idx,
  output logic [LVL_W-1:0]   best
);
  always_comb begin
    hit  = 1'b0;
    idx  = '0;
    best = '0;
    for (int k = 0; k < N; k++) begin
      if (en[k] && lvl[k*LVL_W +: LVL_W] >= best) begin
        hit  = 1'b1;
        idx  = IW'(k);
        best = lvl[k*LVL_W +: LVL_W];
      end
    end
  end
endmodule

// File: rtl/ivc_lvlstk.sv
module ivc_lvlstk
  import ivc_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic [LVL_W-1:0] new_lvl,
  output logic [LVL_W-1:0] ipl
);
  logic [LVL_W-1:0] stk [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ipl <= '0;
      for (int i = 0; i < DEPTH; i++) stk[i] <= '0;
    end else if (push) begin
      ipl    <= new_lvl;
      stk[0] <= ipl;
      for (int i = 1; i < DEPTH; i++) stk[i] <= stk[i-1];
    end else if (pop) begin
      ipl <= stk[0];
      for (int i = 0; i < DEPTH - 1; i++) stk[i] <= stk[i+1];
      stk[DEPTH-1] <= '0;
    end
  end
endmodule

// File: rtl/ivc_top.sv
module ivc_top
  import ivc_pkg::*;
#(
  parameter int NUM_I = 8,
  parameter int STK_D = 4,
  localparam int IW = $clog2(NUM_I),
  localparam int AW = $clog2(NUM_I + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [AW-1:0]    cfg_addr,
  input  logic [7:0]       cfg_wdata,
  input  logic [NM_N-1:0]  nm_req,
  input  logic             xirq,
  input  logic             xmask,
  input  logic             imask,
  input  logic [NUM_I-1:0] irq,
  output logic             cpu_int,
  output logic [15:0]      cpu_vec,
  input  logic             cpu_fetch,
  input  logic             cpu_rti,
  output logic [LVL_W-1:0] cpu_ipl,
  output logic             cop_valid,
  output logic [IW-1:0]    cop_chan,
  input  logic             cop_ready,
  input  logic [1:0]       rst_cause,
  output logic [15:0]      boot_vec
);
  logic [7:0]             base;
  logic [NUM_I*LVL_W-1:0] lvl;
  logic [NUM_I-1:0]       route;
  logic [NUM_I-1:0]       cpu_en, cop_en, cop_busy;
  logic                   cpu_hit;
  logic [IW-1:0]          cpu_idx;
  logic [LVL_W-1:0]       cpu_best, cop_best;
  logic                   x_ok, cop_take;
  src_kind_t              kind;
  logic [7:0]             off;

  ivc_cfg #(.NUM_I(NUM_I), .AW(AW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .base_o(base), .lvl_o(lvl), .route_o(route)
  );

  assign cop_take = cop_valid && cop_ready;

  for (genvar k = 0; k < NUM_I; k++) begin : g_elig
    logic on;
    assign on        = irq[k] && (lvl[k*LVL_W +: LVL_W] != '0);
    assign cpu_en[k] = on && !route[k] && !imask && (lvl[k*LVL_W +: LVL_W] > cpu_ipl);
    assign cop_en[k] = on && route[k] && !cop_busy[k];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 cop_busy[k] <= 1'b0;
      else if (!irq[k])                           cop_busy[k] <= 1'b0;
      else if (cop_take && cop_chan == IW'(k))    cop_busy[k] <= 1'b1;
    end
  end

  ivc_pick #(.N(NUM_I), .IW(IW)) u_pick_cpu (
    .en(cpu_en), .lvl(lvl), .hit(cpu_hit), .idx(cpu_idx), .best(cpu_best)
  );

  ivc_pick #(.N(NUM_I), .IW(IW)) u_pick_cop (
    .en(cop_en), .lvl(lvl), .hit(cop_valid), .idx(cop_chan), .best(cop_best)
  );

  assign x_ok = xirq && !xmask;

  always_comb begin
    kind = SRC_NM;
    if      (nm_req[NM_TRAP]) off = OFF_TRAP;
    else if (nm_req[NM_SWI])  off = OFF_SWI;
    else if (nm_req[NM_ACC2]) off = OFF_ACC2;
    else if (nm_req[NM_ACC1]) off = OFF_ACC1;
    else if (nm_req[NM_ACC0]) off = OFF_ACC0;
    else if (nm_req[NM_SYS])  off = OFF_SYS;
    else if (x_ok) begin
      kind = SRC_X;
      off  = OFF_X;
    end else if (cpu_hit) begin
      kind = SRC_I;
      off  = OFF_I0 + (8'(cpu_idx) << 1);
    end else begin
      kind = SRC_SPUR;
      off  = OFF_SPUR;
    end
  end

  assign cpu_vec = {base, off};
  assign cpu_int = (|nm_req) || x_ok || cpu_hit;

  ivc_lvlstk #(.DEPTH(STK_D)) u_stk (
    .clk(clk), .rst_n(rst_n),
    .push(cpu_fetch),
    .pop(cpu_rti && !cpu_fetch),
    .new_lvl((kind == SRC_I) ? cpu_best : cpu_ipl),
    .ipl(cpu_ipl)
  );

  always_comb begin
    case (rst_cause)
      2'd1:    boot_vec = BOOT_CLK;
      2'd2:    boot_vec = BOOT_WDG;
      default: boot_vec = BOOT_POR;
    endcase
  end

  logic unused_ok;
  assign unused_ok = ^cop_best;
endmodule

// File: rtl/ivc_checker.sv
module ivc_checker
  import ivc_pkg::*;
#(
  parameter int NUM_I = 8,
  parameter int IW    = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NM_N-1:0]  nm_req,
  input logic             xirq,
  input logic             xmask,
  input logic             imask,
  input logic             cpu_int,
  input logic [15:0]      cpu_vec,
  input logic             cpu_fetch,
  input logic [LVL_W-1:0] cpu_ipl,
  input logic             cop_valid,
  input logic [IW-1:0]    cop_chan,
  input logic             cop_ready
);
  logic i_vec;
  assign i_vec = (cpu_vec[7:0] >= OFF_I0) && (cpu_vec[7:0] < OFF_X);

  AST_VEC_ALIGN: assert property (@(posedge clk) disable iff (!rst_n) cpu_vec[0] == 1'b0); // R2
  AST_TRAP_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    nm_req[NM_TRAP] |-> cpu_int && cpu_vec[7:0] == OFF_TRAP); // R3
  AST_X_OVER_I: assert property (@(posedge clk) disable iff (!rst_n)
    (xirq && !xmask && nm_req == '0) |-> cpu_vec[7:0] == OFF_X); // R4
  AST_IMASK_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (imask && nm_req == '0 && !(xirq && !xmask)) |-> !cpu_int); // R5
  AST_NEST_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_fetch && cpu_int && i_vec) |=> cpu_ipl > $past(cpu_ipl)); // R7
  AST_NM_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_fetch && nm_req != '0) |=> $stable(cpu_ipl)); // R8
  AST_PIN_CPU: assert property (@(posedge clk) disable iff (!rst_n)
    cop_valid |-> cop_chan != IW'(NUM_I - 1)); // R9
  AST_COP_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (cop_valid && cop_ready) |=> !(cop_valid && cop_chan == $past(cop_chan))); // R10
  AST_SPUR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_int |-> cpu_vec[7:0] == OFF_SPUR); // R11
endmodule

bind ivc_top ivc_checker #(.NUM_I(NUM_I), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .nm_req(nm_req), .xirq(xirq), .xmask(xmask),
  .imask(imask), .cpu_int(cpu_int), .cpu_vec(cpu_vec), .cpu_fetch(cpu_fetch),
  .cpu_ipl(cpu_ipl), .cop_valid(cop_valid), .cop_chan(cop_chan), .cop_ready(cop_ready)
);

// File: tb/test_ivc_top.sv
module test_ivc_top;
  localparam int NUM_I = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [3:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [5:0] nm_req = '0;
  logic xirq = 1'b0, xmask = 1'b0, imask = 1'b0;
  logic [NUM_I-1:0] irq = '0;
  logic cpu_int;
  logic [15:0] cpu_vec;
  logic cpu_fetch = 1'b0, cpu_rti = 1'b0;
  logic [2:0] cpu_ipl;
  logic cop_valid;
  logic [2:0] cop_chan;
  logic cop_ready = 1'b0;
  logic [1:0] rst_cause = '0;
  logic [15:0] boot_vec;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ivc_top #(.NUM_I(NUM_I), .STK_D(4)) i_ivc_top (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .nm_req(nm_req), .xirq(xirq), .xmask(xmask), .imask(imask), .irq(irq),
    .cpu_int(cpu_int), .cpu_vec(cpu_vec), .cpu_fetch(cpu_fetch), .cpu_rti(cpu_rti),
    .cpu_ipl(cpu_ipl), .cop_valid(cop_valid), .cop_chan(cop_chan), .cop_ready(cop_ready),
    .rst_cause(rst_cause), .boot_vec(boot_vec)
  );

  typedef struct packed {
    logic [5:0] nm;
    logic       x;
    logic       xm;
    logic       im;
    logic [7:0] rq;
    logic       ei;
    logic [7:0] ev;
  } row_t;

  localparam row_t TBL [19] = '{
    '{6'h00, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 8'h10},
    '{6'h00, 1'b0, 1'b0, 1'b0, 8'h01, 1'b1, 8'h1A},
    '{6'h00, 1'b0, 1'b0, 1'b0, 8'h03, 1'b1, 8'h1C},
    '{6'h00, 1'b0, 1'b0, 1'b0, 8'h07, 1'b1, 8'h1E},
    '{6'h00, 1'b0, 1'b0, 1'b0, 8'h08, 1'b0, 8'h10},
    '{6'h00, 1'b0, 1'b0, 1'b0, 8'h10, 1'b0, 8'h10},
    '{6'h00, 1'b0, 1'b0, 1'b0, 8'h80, 1'b1, 8'h28},
    '{6'h00, 1'b0, 1'b0, 1'b0, 8'h60, 1'b1, 8'h26},
    '{6'h00, 1'b0, 1'b0, 1'b1, 8'h07, 1'b0, 8'h10},
    '{6'h00, 1'b1, 1'b0, 1'b0, 8'h07, 1'b1, 8'hF4},
    '{6'h00, 1'b1, 1'b1, 1'b0, 8'h07, 1'b1, 8'h1E},
    '{6'h00, 1'b1, 1'b1, 1'b1, 8'h07, 1'b0, 8'h10},
    '{6'h01, 1'b1, 1'b0, 1'b0, 8'h07, 1'b1, 8'h12},
    '{6'h03, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 8'h14},
    '{6'h06, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 8'h16},
    '{6'h0F, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 8'h18},
    '{6'h1F, 1'b1, 1'b0, 1'b0, 8'hFF, 1'b1, 8'hF6},
    '{6'h3F, 1'b1, 1'b1, 1'b1, 8'hFF, 1'b1, 8'hF8},
    '{6'h08, 1'b0, 1'b0, 1'b1, 8'h00, 1'b1, 8'h18}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
    #5;
  endtask

  task automatic fetch(input string tag, input logic [15:0] exp_vec, input logic [2:0] exp_ipl);
    @(negedge clk);
    cpu_fetch = 1'b1;
    #5 check({tag, " vector at fetch"}, cpu_vec, exp_vec);
    @(negedge clk);
    cpu_fetch = 1'b0;
    #5 check({tag, " level after fetch"}, cpu_ipl, exp_ipl);
  endtask

  task automatic rti(input string tag, input logic [2:0] exp_ipl);
    @(negedge clk);
    cpu_rti = 1'b1;
    @(negedge clk);
    cpu_rti = 1'b0;
    #5 check(tag, cpu_ipl, exp_ipl);
  endtask

  task automatic cop_accept();
    @(negedge clk);
    cop_ready = 1'b1;
    @(negedge clk);
    cop_ready = 1'b0;
    #5;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #5;
    // R1 reset state
    check("R1 cpu_int after reset", cpu_int, 0);
    check("R1 vector after reset", cpu_vec, 16'hFF10);
    check("R1 level after reset", cpu_ipl, 0);
    check("R1 cop_valid after reset", cop_valid, 0);
    irq = 8'h01;
    settle();
    check("R1 default level 1 reaches CPU", cpu_vec, 16'hFF1A);
    irq = 8'h10;
    settle();
    check("R1 default steering is CPU", {cop_valid, cpu_vec}, {1'b0, 16'hFF22});
    irq = '0;

    // R2 configuration for the table
    cfg_write(4'd0, 8'h12);
    cfg_write(4'd1, 8'h03);
    cfg_write(4'd2, 8'h03);
    cfg_write(4'd3, 8'h05);
    cfg_write(4'd4, 8'h00);
    cfg_write(4'd5, 8'h87);
    cfg_write(4'd6, 8'h02);
    cfg_write(4'd7, 8'h02);
    cfg_write(4'd8, 8'h81);

    for (int r = 0; r < 19; r++) begin
      @(negedge clk);
      nm_req = TBL[r].nm; xirq = TBL[r].x; xmask = TBL[r].xm;
      imask = TBL[r].im; irq = TBL[r].rq;
      #5;
      check($sformatf("table(R2 R3 R4 R5 R6 R9 R11) row %0d int", r), cpu_int, TBL[r].ei);
      check($sformatf("table(R2 R3 R4 R5 R6 R9 R11) row %0d vec", r), cpu_vec, {8'h12, TBL[r].ev});
    end
    @(negedge clk);
    nm_req = '0; xirq = 0; xmask = 0; imask = 0; irq = '0;

    // R7 R8 nesting
    irq = 8'h20;
    fetch("R8 level-2 entry", 16'h1224, 3'd2);
    irq = 8'h21;
    fetch("R7 level-3 preempts level 2", 16'h121A, 3'd3);
    irq = 8'hA1;
    settle();
    check("R7 equal or lower level does not preempt", cpu_int, 0);
    irq = 8'hA5;
    settle();
    check("R7 level 5 preempts level 3", {cpu_int, cpu_vec}, {1'b1, 16'h121E});
    irq = '0;
    rti("R8 return restores level 2", 3'd2);
    rti("R8 return restores level 0", 3'd0);

    // R13 overflow of a 4-deep stack
    irq = 8'h20; fetch("R13 push a", 16'h1224, 3'd2);
    irq = 8'h01; fetch("R13 push b", 16'h121A, 3'd3);
    irq = 8'h04; fetch("R13 push c", 16'h121E, 3'd5);
    irq = '0;
    cfg_write(4'd5, 8'h07);
    irq = 8'h10; fetch("R13 push d", 16'h1222, 3'd7);
    irq = '0; nm_req = 6'h20;
    fetch("R8 trap keeps level", 16'h12F8, 3'd7);
    nm_req = '0;
    rti("R13 pop 1", 3'd7);
    rti("R13 pop 2", 3'd5);
    rti("R13 pop 3", 3'd3);
    rti("R13 pop 4", 3'd2);
    rti("R13 pop of empty stack", 3'd0);

    // R11 spurious fetch
    fetch("R11 spurious", 16'h1210, 3'd0);
    rti("R11 return after spurious", 3'd0);

    // R9 R10 coprocessor channel
    cfg_write(4'd5, 8'h87);
    cfg_write(4'd2, 8'h83);
    cfg_write(4'd8, 8'h87);
    irq = 8'h92;
    settle();
    check("R10 cop offers highest level", {cop_valid, cop_chan}, {1'b1, 3'd4});
    check("R9 pin stays on CPU", {cpu_int, cpu_vec}, {1'b1, 16'h1228});
    imask = 1'b1;
    settle();
    check("R10 cop ignores imask", {cop_valid, cop_chan}, {1'b1, 3'd4});
    settle();
    check("R10 offer held under back-pressure", {cop_valid, cop_chan}, {1'b1, 3'd4});
    cop_accept();
    check("R10 next channel after handshake", {cop_valid, cop_chan}, {1'b1, 3'd1});
    cop_accept();
    check("R10 all channels taken", cop_valid, 0);
    irq = 8'h82;
    settle();
    check("R10 taken channel stays withheld", cop_valid, 0);
    irq = 8'h92;
    settle();
    check("R10 channel offered again after drop", {cop_valid, cop_chan}, {1'b1, 3'd4});
    imask = 1'b0;
    irq = '0;

    // R14 out-of-range config writes
    cfg_write(4'd9, 8'h00);
    cfg_write(4'd15, 8'h00);
    irq = 8'h04;
    settle();
    check("R14 writes above range ignored", cpu_vec, 16'h121E);
    irq = '0;

    // R12 restart addresses
    rst_cause = 2'd0; #1 check("R12 cause 0", boot_vec, 16'hFFFE);
    rst_cause = 2'd1; #1 check("R12 cause 1", boot_vec, 16'hFFFC);
    rst_cause = 2'd2; #1 check("R12 cause 2", boot_vec, 16'hFFFA);
    rst_cause = 2'd3; #1 check("R12 cause 3", boot_vec, 16'hFFFE);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule